// File: doc/BRIEF.md
# Parkable Two-Master Bus Arbiter

This block decides which master drives a shared internal bus: a processor core, a DMA engine, or an external master that takes part only while the chip's external bus grant input is negated. Each internal master raises a request line. The external master has its own request line. The arbiter answers with three grant outputs, and exactly one of them is high in every cycle after reset.

Ownership moves only at bus-cycle boundaries, which a done strobe marks. On that strobe the arbiter computes the next owner from the requests, a 2-bit park-mode field, and a DMA high-priority flag, and it registers that owner. The park mode chooses how a tie between the core and the DMA is broken. It also chooses where the bus rests when no master requests it: on the core, on the DMA, on the master that held it last, or alternating between the two. The arbiter keeps a record of the last internal owner. That record decides round-robin ties, defines the "current" master, and gives the resting place after the external master leaves.

Top module: `arbiter_top`

## Requirements
- R1: After reset exactly one of grantCore, grantDma and grantExt is high in every cycle.
- R2: While rstN is low, and in the first cycle after it is released, grantCore is high and the other two grants are low.
- R3: The grant outputs change only on the clock edge at which cycleDone is high; in any cycle where cycleDone is low they keep their value.
- R4: With parkMode 2'b01, the core wins when both internal masters request, and the bus rests on the core when neither requests.
- R5: With parkMode 2'b10, the DMA wins when both internal masters request, and the bus rests on the DMA when neither requests.
- R6: With parkMode 2'b00, when both internal masters request, the one that was not the last internal owner wins. When neither requests, the bus stays with the last internal owner.
- R7: With parkMode 2'b11, when both internal masters request, the last internal owner (the current master) keeps the bus. When only the other master requests, that master takes the bus. When neither requests, the bus stays with the current master.
- R8: While extBusGrant is high, a DMA request that comes with dmaHiPri high wins over a core request in every park mode.
- R9: While extBusGrant is low, a request from the external master wins over everything. Without one, the core wins over the DMA whatever the values of parkMode and dmaHiPri.
- R10: While extBusGrant is high, extReq is ignored and grantExt never rises.
- R11: When exactly one internal master requests and no external-master rule applies, that master gets the grant in every park mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| parkMode | input | 2 | Parking policy: 00 round-robin, 01 core, 10 DMA, 11 current master |
| coreReq | input | 1 | Core bus request |
| dmaReq | input | 1 | DMA bus request |
| dmaHiPri | input | 1 | DMA maximum-bandwidth priority flag |
| extReq | input | 1 | External master bus request |
| extBusGrant | input | 1 | External bus grant to this chip; low hands priority to the external master |
| cycleDone | input | 1 | Bus-cycle boundary strobe; the owner may change only here |
| grantCore | output | 1 | Bus granted to the core |
| grantDma | output | 1 | Bus granted to the DMA |
| grantExt | output | 1 | Bus granted to the external master |

## Verification
The assertions assume that the request, priority, mode and grant inputs are steady around each rising edge, and that cycleDone is a single-cycle pulse that the bus raises only at a cycle boundary. They also assume that parkMode holds one of its four codes. The bench follows these rules by changing every input on the falling edge. It raises cycleDone for exactly one cycle per arbitration step and holds all inputs constant across the cycle in which a grant is sampled.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int NUM_GRANTS = 3;
  localparam int OWNER_W    = $clog2(NUM_GRANTS);

  typedef enum logic [OWNER_W-1:0] {
    OWN_CORE = 2'd0,
    OWN_DMA  = 2'd1,
    OWN_EXT  = 2'd2
  } owner_e;

  typedef enum logic [1:0] {
    PARK_ROUND   = 2'b00,
    PARK_CORE    = 2'b01,
    PARK_DMA     = 2'b10,
    PARK_CURRENT = 2'b11
  } park_e;

  typedef struct packed {
    logic   load;
    owner_e nextOwner;
  } arbStrobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic [1:0] parkMode,
  input  logic       coreReq,
  input  logic       dmaReq,
  input  logic       dmaHiPri,
  input  logic       extReq,
  input  logic       extBusGrant,
  input  logic       cycleDone,
  input  owner_e     lastInternal,
  output arbStrobe_t strobe
);

  owner_e winner;
  owner_e otherInternal;
  park_e  mode;

  assign mode          = park_e'(parkMode);
  assign otherInternal = (lastInternal == OWN_CORE) ? OWN_DMA : OWN_CORE;

  always_comb begin
    winner = lastInternal;
    if (!extBusGrant && extReq) begin
      winner = OWN_EXT;
    end else if (!extBusGrant && coreReq) begin
      winner = OWN_CORE;
    end else if (!extBusGrant && dmaReq) begin
      winner = OWN_DMA;
    end else if (dmaReq && dmaHiPri) begin
      winner = OWN_DMA;
    end else if (coreReq && dmaReq) begin
      unique case (mode)
        PARK_ROUND:   winner = otherInternal;
        PARK_CORE:    winner = OWN_CORE;
        PARK_DMA:     winner = OWN_DMA;
        PARK_CURRENT: winner = lastInternal;
        default:      winner = lastInternal;
      endcase
    end else if (coreReq) begin
      winner = OWN_CORE;
    end else if (dmaReq) begin
      winner = OWN_DMA;
    end else begin
      unique case (mode)
        PARK_CORE: winner = OWN_CORE;
        PARK_DMA:  winner = OWN_DMA;
        default:   winner = lastInternal;
      endcase
    end
  end

  assign strobe.load      = cycleDone;
  assign strobe.nextOwner = winner;

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter owner_e RESET_OWNER = OWN_CORE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  arbStrobe_t            strobe,
  output owner_e                lastInternal,
  output logic [NUM_GRANTS-1:0] grantVec
);

  localparam owner_e RESET_LAST = (RESET_OWNER == OWN_DMA) ? OWN_DMA : OWN_CORE;

  owner_e owner;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner        <= RESET_OWNER;
      lastInternal <= RESET_LAST;
    end else if (strobe.load) begin
      owner <= strobe.nextOwner;
      if (strobe.nextOwner != OWN_EXT) begin
        lastInternal <= strobe.nextOwner;
      end
    end
  end

  for (genvar g = 0; g < NUM_GRANTS; g++) begin : g_grant
    assign grantVec[g] = (owner == owner_e'(g));
  end

endmodule

// File: rtl/arbiter_top.sv
module arbiter_top
  import arb_pkg::*;
#(
  parameter owner_e RESET_OWNER = OWN_CORE
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] parkMode,
  input  logic       coreReq,
  input  logic       dmaReq,
  input  logic       dmaHiPri,
  input  logic       extReq,
  input  logic       extBusGrant,
  input  logic       cycleDone,
  output logic       grantCore,
  output logic       grantDma,
  output logic       grantExt
);

  arbStrobe_t            strobe;
  owner_e                lastInternal;
  logic [NUM_GRANTS-1:0] grantVec;

  arb_ctrl u_ctrl (
    .parkMode     (parkMode),
    .coreReq      (coreReq),
    .dmaReq       (dmaReq),
    .dmaHiPri     (dmaHiPri),
    .extReq       (extReq),
    .extBusGrant  (extBusGrant),
    .cycleDone    (cycleDone),
    .lastInternal (lastInternal),
    .strobe       (strobe)
  );

  arb_datapath #(.RESET_OWNER(RESET_OWNER)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .lastInternal (lastInternal),
    .grantVec     (grantVec)
  );

  assign grantCore = grantVec[OWN_CORE];
  assign grantDma  = grantVec[OWN_DMA];
  assign grantExt  = grantVec[OWN_EXT];

endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] parkMode,
  input logic       coreReq,
  input logic       dmaReq,
  input logic       dmaHiPri,
  input logic       extReq,
  input logic       extBusGrant,
  input logic       cycleDone,
  input logic       grantCore,
  input logic       grantDma,
  input logic       grantExt
);

  p_one_grant_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({grantCore, grantDma, grantExt}) == 1);

  p_hold_no_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cycleDone |=> $stable({grantCore, grantDma, grantExt}));

  p_core_park_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && extBusGrant && parkMode == 2'b01 && !(dmaReq && dmaHiPri)
     && (coreReq || !dmaReq)) |=> grantCore);

  p_dma_park_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && extBusGrant && parkMode == 2'b10 && (dmaReq || !coreReq))
    |=> grantDma);

  p_hipri_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && extBusGrant && dmaReq && dmaHiPri) |=> grantDma);

  p_ext_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && !extBusGrant && extReq) |=> grantExt);

  p_core_second_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && !extBusGrant && !extReq && coreReq) |=> grantCore);

  p_ext_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && extBusGrant) |=> !grantExt);

endmodule

bind arbiter_top arb_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .parkMode    (parkMode),
  .coreReq     (coreReq),
  .dmaReq      (dmaReq),
  .dmaHiPri    (dmaHiPri),
  .extReq      (extReq),
  .extBusGrant (extBusGrant),
  .cycleDone   (cycleDone),
  .grantCore   (grantCore),
  .grantDma    (grantDma),
  .grantExt    (grantExt)
);

// File: tb/arbiter_top_tb.sv
module arbiter_top_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] parkMode;
  logic       coreReq, dmaReq, dmaHiPri, extReq, extBusGrant, cycleDone;
  logic       grantCore, grantDma, grantExt;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  localparam logic [2:0] G_CORE = 3'b001;
  localparam logic [2:0] G_DMA  = 3'b010;
  localparam logic [2:0] G_EXT  = 3'b100;

  always #4 clk = ~clk;

  arbiter_top u_dut (
    .clk(clk), .rstN(rstN), .parkMode(parkMode), .coreReq(coreReq),
    .dmaReq(dmaReq), .dmaHiPri(dmaHiPri), .extReq(extReq),
    .extBusGrant(extBusGrant), .cycleDone(cycleDone),
    .grantCore(grantCore), .grantDma(grantDma), .grantExt(grantExt)
  );

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {grantExt, grantDma, grantCore};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s grants{ext,dma,core} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] mode, input logic c, input logic d,
                      input logic hi, input logic e, input logic eg, input logic dn);
    @(negedge clk);
    parkMode = mode; coreReq = c; dmaReq = d; dmaHiPri = hi;
    extReq = e; extBusGrant = eg; cycleDone = dn;
    @(posedge clk);
    @(negedge clk);
    cycleDone = 1'b0;
  endtask

  task automatic testReset();
    check("R2", G_CORE);
    step(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R1", G_CORE);
  endtask

  task automatic testHold();
    step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R3", G_CORE);
    step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R11", G_DMA);
  endtask

  task automatic testParkCore();
    step(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R4 both", G_CORE);
    step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R4 idle", G_CORE);
  endtask

  task automatic testParkDma();
    step(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R5 both", G_DMA);
    step(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R11 core alone", G_CORE);
    step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R5 idle", G_DMA);
  endtask

  task automatic testRoundRobin();
    step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R6 alt core", G_CORE);
    step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R6 alt dma", G_DMA);
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R6 idle", G_DMA);
  endtask

  task automatic testCurrent();
    step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R7 keep", G_DMA);
    step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R7 other", G_CORE);
    step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R7 keep core", G_CORE);
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R7 idle", G_CORE);
  endtask

  task automatic testHiPri();
    step(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R8 mode01", G_DMA);
    step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step(2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R8 mode11", G_DMA);
  endtask

  task automatic testExternal();
    step(2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R9 ext", G_EXT);
    step(2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R9 core second", G_CORE);
    step(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R10 ext ignored", G_CORE);
    step(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R10 idle", G_DMA);
  endtask

  initial begin
    rstN = 1'b0; parkMode = 2'b00; coreReq = 1'b0; dmaReq = 1'b0;
    dmaHiPri = 1'b0; extReq = 1'b0; extBusGrant = 1'b1; cycleDone = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 in reset", G_CORE);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    testReset();
    testHold();
    testParkCore();
    testParkDma();
    testRoundRobin();
    testCurrent();
    testHiPri();
    testExternal();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule